// File: doc/BRIEF.md
# Dual-Slot Accumulator Processor

This block is a small accumulator machine that packs two 20-bit instructions into every 40-bit memory word. It owns a 4096-word synchronous memory, a 12-bit address register and a 40-bit buffer register that carry every memory cycle, a 40-bit accumulator, a word counter, and a holding register for the second instruction of the current word. Each instruction has an 8-bit opcode in its upper bits and a 12-bit address in its lower bits. The lower 20 bits of a word form the first slot, called the left slot, and the upper 20 bits form the right slot.

The machine fetches one word and runs its left slot. It then runs the right slot from the holding register, with no second fetch, and moves on to the next word. A jump names a target word and one of its two slots. An operand access always moves through the address and buffer registers. The address goes into the address register, then a read strobe loads the buffer from memory, or a write strobe stores the buffer to memory.

A program is written into memory through a test port while reset is held. When reset is released the program runs until it executes a halt, and the test port can then read memory back. The accumulator is visible at an output.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted, `acc_q` is 0 and `halt` is 0. After reset is released, execution starts at the left slot of word 0.
- R2: A word holds the left slot in bits 19:0 and the right slot in bits 39:20. In each slot the opcode is bits 19:12 and the address is bits 11:0.
- R3: Opcode 0x01 loads mem[addr] into the accumulator. Opcode 0x02 loads the two's-complement negation of mem[addr].
- R4: Opcode 0x05 adds mem[addr] to the accumulator and opcode 0x06 subtracts it. Both wrap modulo 2^40.
- R5: Opcode 0x21 writes the accumulator to mem[addr] and leaves the accumulator unchanged.
- R6: Opcode 0x0D continues at the left slot of word addr. Opcode 0x0E continues at the right slot of word addr.
- R7: Opcodes 0x0F (left slot) and 0x10 (right slot) jump only when accumulator bit 39 is 0, and zero counts as nonnegative. Otherwise execution continues with the next instruction in sequence.
- R8: The right slot runs from the copy taken when its word was fetched, even if the left slot has rewritten that word. The word counter advances by one only after a right slot completes.
- R9: Opcode 0x00 and every opcode not listed above assert `halt`. `halt` then stays high and the accumulator is frozen until reset.
- R10: While reset is asserted, `tp_we` writes `tp_wdata` to mem[`tp_addr`]. `tp_rdata` shows mem[`tp_addr`] one clock after the address is presented.
- R11: The read strobe and the write strobe are never active in the same cycle. A write only ever comes from a store instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the preload window |
| tp_we | input | 1 | Test-port write enable, honoured only in reset |
| tp_addr | input | 12 | Test-port word address |
| tp_wdata | input | 40 | Test-port write data |
| tp_rdata | output | 40 | Registered test-port read data |
| acc_q | output | 40 | Accumulator |
| halt | output | 1 | Machine has stopped |

## Verification
Several properties are checked on every clock cycle by the assertions:
- the two memory strobes never overlap, and only a store ever writes;
- `halt` stays high once set, and the accumulator holds still while it does;
- the word counter steps only after a right slot;
- a conditional jump with a negative accumulator falls through to the next instruction.

The arithmetic results, the slot and field layout, which slot a jump lands on, and the sign boundary of zero can only be shown by the bench. It runs whole programs and reads memory back. The bench also covers the rule that the right slot runs from its buffered copy even after the left slot has rewritten that word.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int ADDR_W = 12,
  parameter int OP_W   = 8,
  parameter int DATA_W = 2 * (OP_W + ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tp_we,
  input  logic [ADDR_W-1:0] tp_addr,
  input  logic [DATA_W-1:0] tp_wdata,
  output logic [DATA_W-1:0] tp_rdata,
  output logic [DATA_W-1:0] acc_q,
  output logic              halt
);
  localparam int IW    = OP_W + ADDR_W;
  localparam int DEPTH = 1 << ADDR_W;

  localparam logic [OP_W-1:0] OP_LD  = 8'h01;
  localparam logic [OP_W-1:0] OP_NLD = 8'h02;
  localparam logic [OP_W-1:0] OP_ADD = 8'h05;
  localparam logic [OP_W-1:0] OP_SUB = 8'h06;
  localparam logic [OP_W-1:0] OP_ST  = 8'h21;
  localparam logic [OP_W-1:0] OP_JL  = 8'h0D;
  localparam logic [OP_W-1:0] OP_JR  = 8'h0E;
  localparam logic [OP_W-1:0] OP_CJL = 8'h0F;
  localparam logic [OP_W-1:0] OP_CJR = 8'h10;

  typedef enum logic [3:0] {
    ST_FADDR, ST_FREAD, ST_SPLIT, ST_EXEC,
    ST_OPREAD, ST_OPUSE, ST_WRITE, ST_NEXT, ST_HALT
  } state_t;

  state_t              state;
  logic [ADDR_W-1:0]   pc, mar;
  logic [DATA_W-1:0]   mbr, acc;
  logic [IW-1:0]       ir, ibr;
  logic                right_sel;
  logic [DATA_W-1:0]   mem [DEPTH];

  wire [OP_W-1:0]   op     = ir[IW-1:ADDR_W];
  wire [ADDR_W-1:0] ad     = ir[ADDR_W-1:0];
  wire              mem_rd = (state == ST_FREAD) || (state == ST_OPREAD);
  wire              mem_we = (state == ST_WRITE);
  wire              acc_nn = ~acc[DATA_W-1];

  assign acc_q = acc;
  assign halt  = (state == ST_HALT);

  always_ff @(posedge clk) begin
    if (mem_we)
      mem[mar] <= mbr;
    else if (!rst_n && tp_we)
      mem[tp_addr] <= tp_wdata;
  end

  always_ff @(posedge clk)
    tp_rdata <= mem[tp_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_FADDR;
      pc        <= '0;
      mar       <= '0;
      mbr       <= '0;
      acc       <= '0;
      ir        <= '0;
      ibr       <= '0;
      right_sel <= 1'b0;
    end else begin
      case (state)
        ST_FADDR: begin
          mar   <= pc;
          state <= ST_FREAD;
        end
        ST_FREAD: begin
          mbr   <= mem[mar];
          state <= ST_SPLIT;
        end
        ST_SPLIT: begin
          ir    <= right_sel ? mbr[DATA_W-1:IW] : mbr[IW-1:0];
          ibr   <= mbr[DATA_W-1:IW];
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          case (op)
            OP_LD, OP_NLD, OP_ADD, OP_SUB: begin
              mar   <= ad;
              state <= ST_OPREAD;
            end
            OP_ST: begin
              mar   <= ad;
              mbr   <= acc;
              state <= ST_WRITE;
            end
            OP_JL, OP_JR: begin
              pc        <= ad;
              right_sel <= (op == OP_JR);
              state     <= ST_FADDR;
            end
            OP_CJL, OP_CJR: begin
              if (acc_nn) begin
                pc        <= ad;
                right_sel <= (op == OP_CJR);
                state     <= ST_FADDR;
              end else begin
                state <= ST_NEXT;
              end
            end
            default: state <= ST_HALT;
          endcase
        end
        ST_OPREAD: begin
          mbr   <= mem[mar];
          state <= ST_OPUSE;
        end
        ST_OPUSE: begin
          case (op)
            OP_LD:   acc <= mbr;
            OP_NLD:  acc <= -mbr;
            OP_ADD:  acc <= acc + mbr;
            OP_SUB:  acc <= acc - mbr;
            default: acc <= acc;
          endcase
          state <= ST_NEXT;
        end
        ST_WRITE: state <= ST_NEXT;
        ST_NEXT: begin
          if (!right_sel) begin
            right_sel <= 1'b1;
            ir        <= ibr;
            state     <= ST_EXEC;
          end else begin
            right_sel <= 1'b0;
            pc        <= pc + 1'b1;
            state     <= ST_FADDR;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  a_r11_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  a_r11_write_from_store: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (op == OP_ST));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (halt && $stable(acc)));

  a_r8_pc_after_right: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEXT && right_sel) |=> (pc == $past(pc) + 1'b1));

  a_r8_left_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEXT && !right_sel) |=> ($stable(pc) && state == ST_EXEC));

  a_r7_negative_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && (op == OP_CJL || op == OP_CJR) && !acc_nn)
      |=> (state == ST_NEXT && $stable(pc)));
endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  localparam int CLK_P = 10;

  localparam logic [7:0] HLT = 8'h00, LD = 8'h01, NLD = 8'h02, ADD = 8'h05,
                         SUB = 8'h06, ST = 8'h21, JL = 8'h0D, JR = 8'h0E,
                         CJL = 8'h0F, CJR = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tp_we = 1'b0;
  logic [11:0] tp_addr = '0;
  logic [39:0] tp_wdata = '0;
  logic [39:0] tp_rdata, acc_q;
  logic        halt;

  int n_run = 0;
  int n_fail = 0;

  acc_cpu u_acc_cpu (
    .clk(clk), .rst_n(rst_n), .tp_we(tp_we), .tp_addr(tp_addr),
    .tp_wdata(tp_wdata), .tp_rdata(tp_rdata), .acc_q(acc_q), .halt(halt)
  );

  always #(CLK_P/2) clk = ~clk;

  // {opcode, first value at 100, operand at 101, expected accumulator}
  localparam logic [127:0] VEC [7] = '{
    {LD,  40'h00_0000_0007, 40'h12_3456_789A, 40'h12_3456_789A},
    {NLD, 40'h00_0000_0009, 40'h00_0000_0005, 40'hFF_FFFF_FFFB},
    {NLD, 40'h00_0000_0009, 40'h00_0000_0000, 40'h00_0000_0000},
    {ADD, 40'hFF_FFFF_FFFF, 40'h00_0000_0001, 40'h00_0000_0000},
    {ADD, 40'h00_0000_0007, 40'h00_0000_0008, 40'h00_0000_000F},
    {SUB, 40'h00_0000_0003, 40'h00_0000_0005, 40'hFF_FFFF_FFFE},
    {SUB, 40'h80_0000_0000, 40'h00_0000_0001, 40'h7F_FFFF_FFFF}
  };

  function automatic logic [19:0] ins(input logic [7:0] o, input logic [11:0] a);
    return {o, a};
  endfunction

  function automatic logic [39:0] wd(input logic [19:0] l, input logic [19:0] r);
    return {r, l};
  endfunction

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hold_reset;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic poke(input logic [11:0] a, input logic [39:0] d);
    tp_we = 1'b1; tp_addr = a; tp_wdata = d;
    @(negedge clk);
    tp_we = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [39:0] d);
    tp_addr = a;
    @(negedge clk);
    d = tp_rdata;
  endtask

  task automatic run_wait(input string tag);
    int t;
    rst_n = 1'b1;
    t = 0;
    while (!halt && t < 1000) begin
      @(negedge clk);
      t++;
    end
    chk({tag, " halt reached"}, {39'd0, halt}, 40'd1);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL R9 watchdog act=running exp=halted");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [39:0] d;
    // R1 reset state, R10 preload and readback
    hold_reset();
    chk("R1 acc in reset", acc_q, 40'd0);
    chk("R1 halt in reset", {39'd0, halt}, 40'd0);
    poke(12'd300, 40'hAB_CDEF_0123);
    peek(12'd300, d);
    chk("R10 test port readback", d, 40'hAB_CDEF_0123);

    // R3 R4 R5 table walk
    for (int i = 0; i < 7; i++) begin
      logic [127:0] v;
      v = VEC[i];
      hold_reset();
      poke(12'd0, wd(ins(LD, 12'd100), ins(v[127:120], 12'd101)));
      poke(12'd1, wd(ins(ST, 12'd102), ins(HLT, 12'd0)));
      poke(12'd100, v[119:80]);
      poke(12'd101, v[79:40]);
      poke(12'd102, 40'd0);
      run_wait("R3 R4 table");
      chk($sformatf("R3 R4 row %0d acc", i), acc_q, v[39:0]);
      peek(12'd102, d);
      chk($sformatf("R5 row %0d stored", i), d, v[39:0]);
    end

    // R1 R2 R6 jump to right slot: left slot of word 5 must be skipped
    hold_reset();
    chk("R1 acc cleared by reset", acc_q, 40'd0);
    poke(12'd0, wd(ins(JR, 12'd5), ins(HLT, 12'd0)));
    poke(12'd5, wd(ins(LD, 12'd100), ins(LD, 12'd101)));
    poke(12'd6, wd(ins(HLT, 12'd0), ins(HLT, 12'd0)));
    poke(12'd100, 40'd11);
    poke(12'd101, 40'd22);
    run_wait("R6 jump right");
    chk("R6 R2 jump right slot", acc_q, 40'd22);

    // R6 jump to left slot
    hold_reset();
    poke(12'd0, wd(ins(JL, 12'd3), ins(LD, 12'd100)));
    poke(12'd3, wd(ins(LD, 12'd101), ins(HLT, 12'd0)));
    run_wait("R6 jump left");
    chk("R6 jump left slot", acc_q, 40'd22);

    // R7 negative accumulator: no jump
    hold_reset();
    poke(12'd0, wd(ins(LD, 12'd100), ins(CJL, 12'd4)));
    poke(12'd1, wd(ins(LD, 12'd101), ins(HLT, 12'd0)));
    poke(12'd4, wd(ins(LD, 12'd102), ins(HLT, 12'd0)));
    poke(12'd100, 40'h80_0000_0000);
    poke(12'd101, 40'd33);
    poke(12'd102, 40'd44);
    run_wait("R7 negative");
    chk("R7 negative falls through", acc_q, 40'd33);

    // R7 zero accumulator: jump taken
    hold_reset();
    poke(12'd100, 40'd0);
    run_wait("R7 zero");
    chk("R7 zero takes jump", acc_q, 40'd44);

    // R7 positive accumulator, right-slot target
    hold_reset();
    poke(12'd0, wd(ins(LD, 12'd100), ins(CJR, 12'd4)));
    poke(12'd4, wd(ins(LD, 12'd101), ins(LD, 12'd102)));
    poke(12'd5, wd(ins(HLT, 12'd0), ins(HLT, 12'd0)));
    poke(12'd100, 40'd1);
    run_wait("R7 right");
    chk("R7 conditional to right slot", acc_q, 40'd44);

    // R8 right slot runs from its buffer after the left slot rewrites the word
    hold_reset();
    poke(12'd0, wd(ins(LD, 12'd100), ins(HLT, 12'd0)));
    poke(12'd0, wd(ins(LD, 12'd100), ins(JL, 12'd1)));
    poke(12'd1, wd(ins(ST, 12'd1), ins(ADD, 12'd101)));
    poke(12'd2, wd(ins(HLT, 12'd0), ins(HLT, 12'd0)));
    poke(12'd100, 40'h00000_12345);
    poke(12'd101, 40'd5);
    run_wait("R8 buffer");
    chk("R8 buffered right slot ran", acc_q, 40'h00000_1234A);
    peek(12'd1, d);
    chk("R8 R5 word rewritten", d, 40'h00000_12345);

    // R9 undefined opcode halts and freezes the accumulator
    hold_reset();
    poke(12'd0, wd(ins(LD, 12'd100), ins(8'hFF, 12'd0)));
    poke(12'd1, wd(ins(LD, 12'd101), ins(HLT, 12'd0)));
    run_wait("R9 undefined");
    chk("R9 acc at undefined opcode", acc_q, 40'h00000_12345);
    repeat (20) @(negedge clk);
    chk("R9 halt sticky", {39'd0, halt}, 40'd1);
    chk("R9 acc frozen", acc_q, 40'h00000_12345);

    // R10 test port write ignored outside reset
    tp_we = 1'b1; tp_addr = 12'd300; tp_wdata = 40'd0;
    @(negedge clk);
    tp_we = 1'b0;
    peek(12'd300, d);
    chk("R10 write ignored when running", d, 40'hAB_CDEF_0123);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule